// File: doc/BRIEF.md
# Interrupt Status Register

This block holds the eight-bit interrupt status of a USB host controller together with its enable mask and produces one combined interrupt request. Event pulses from the surrounding controller set latched status bits:
- transfer completion on channel A and on channel B;
- babble detection;
- the 1 ms frame tick;
- cable insertion or removal;
- bus reset or resume.

Software reads the status through `stat_q`. It clears chosen bits by writing ones to their positions, and bits written with zero keep their value.

Two positions do not behave like ordinary latches. The shared position 6 records resume detection while the mode input is high, and bus-reset detection while it is low. The other source is ignored at that time. Position 7 is not stored at all: it shows the present level of the D+ line. Position 3 is reserved and always reads zero. The enable register selects which latched bits drive `irq`.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is asserted and after it is released with no event, status bits 0 to 6 read 0, the enable register reads 0x00, and `irq` is low.
- R2: A pulse on `evt_xfer_a` sets status bit 0 and a pulse on `evt_xfer_b` sets status bit 1, visible one clock edge after the pulse.
- R3: A pulse on `evt_babble` sets status bit 2 and a pulse on `evt_frame` sets status bit 4; simultaneous pulses set both.
- R4: A pulse on `evt_cable` sets status bit 5, which then stays set through idle cycles until software clears it.
- R5: With `resume_mode` = 1, `evt_resume` sets status bit 6 and `evt_busrst` is ignored; with `resume_mode` = 0, `evt_busrst` sets bit 6 and `evt_resume` is ignored.
- R6: Status bit 7 equals `line_dp` combinationally at all times, and a status write has no effect on it.
- R7: A status write (`wr_stat` = 1) clears every latched bit whose position holds a 1 in `wr_data` and leaves bits written with 0 unchanged.
- R8: When an event sets a bit in the same cycle that a status write clears it, the bit ends up set.
- R9: `irq` is high exactly when some latched bit (positions 0–2, 4–6) is set and its enable bit is set; `line_dp` never drives `irq`.
- R10: Status bit 3 always reads 0, and writing a 1 to it has no effect.
- R11: A write with `wr_en` = 1 loads the enable register from `wr_data` at the clock edge; enable bits 3 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_xfer_a | input | 1 | Channel A transfer-done pulse |
| evt_xfer_b | input | 1 | Channel B transfer-done pulse |
| evt_babble | input | 1 | Babble-detected pulse |
| evt_frame | input | 1 | 1 ms frame tick pulse |
| evt_cable | input | 1 | Cable insertion or removal pulse |
| evt_busrst | input | 1 | Bus reset detected pulse |
| evt_resume | input | 1 | Resume detected pulse |
| resume_mode | input | 1 | Selects resume (1) or bus reset (0) as the source for bit 6 |
| line_dp | input | 1 | Live D+ line level |
| wr_stat | input | 1 | Write-one-to-clear strobe for the status register |
| wr_en | input | 1 | Load strobe for the enable register |
| wr_data | input | 8 | Write data for either register |
| stat_q | output | 8 | Status read view |
| en_q | output | 8 | Enable register read view |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets a status clear that lands in the same cycle as a set event. A design that let the clear win would lose that event without any trace. It drives the bit-6 source that is not selected and checks that bit 6 stays clear, which catches a design that ORs both detectors together. It writes ones to positions 3 and 7 of both registers and holds `line_dp` high while all enables are set. A design that latched the pin, stored the reserved bit or let bit 7 into the interrupt would then show a wrong read value or a spurious `irq`.

// File: rtl/isr_pkg.sv
package isr_pkg;
   localparam int unsigned ISR_W   = 8;
   localparam int unsigned POS_XA  = 0;
   localparam int unsigned POS_XB  = 1;
   localparam int unsigned POS_BAB = 2;
   localparam int unsigned POS_RSV = 3;
   localparam int unsigned POS_FRM = 4;
   localparam int unsigned POS_CBL = 5;
   localparam int unsigned POS_SHR = 6;
   localparam int unsigned POS_DP  = 7;

   typedef enum logic [1:0] {
      CELL_LATCH = 2'd0,
      CELL_LIVE  = 2'd1,
      CELL_ZERO  = 2'd2
   } cell_kind_e;
endpackage

// File: rtl/isr_event_map.sv
module isr_event_map #(
   parameter int unsigned W       = isr_pkg::ISR_W,
   parameter int unsigned P_XA    = isr_pkg::POS_XA,
   parameter int unsigned P_XB    = isr_pkg::POS_XB,
   parameter int unsigned P_BAB   = isr_pkg::POS_BAB,
   parameter int unsigned P_FRM   = isr_pkg::POS_FRM,
   parameter int unsigned P_CBL   = isr_pkg::POS_CBL,
   parameter int unsigned P_SHR   = isr_pkg::POS_SHR
) (
   input  logic         evt_xfer_a,
   input  logic         evt_xfer_b,
   input  logic         evt_babble,
   input  logic         evt_frame,
   input  logic         evt_cable,
   input  logic         evt_busrst,
   input  logic         evt_resume,
   input  logic         resume_mode,
   output logic [W-1:0] set_vec
);
   always_comb begin
      set_vec        = '0;
      set_vec[P_XA]  = evt_xfer_a;
      set_vec[P_XB]  = evt_xfer_b;
      set_vec[P_BAB] = evt_babble;
      set_vec[P_FRM] = evt_frame;
      set_vec[P_CBL] = evt_cable;
      // shared position: source picked by the mode input
      set_vec[P_SHR] = resume_mode ? evt_resume : evt_busrst;
   end
endmodule

// File: rtl/isr_bit_cell.sv
module isr_bit_cell #(
   parameter isr_pkg::cell_kind_e KIND     = isr_pkg::CELL_LATCH,
   parameter bit                  SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic live_i,
   output logic q_o,
   output logic pend_o
);
   generate
      if (KIND == isr_pkg::CELL_LATCH) begin : g_latch
         logic flag_r;
         logic flag_nx;
         if (SET_WINS) begin : g_set_pri
            assign flag_nx = set_i | (flag_r & ~clr_i);
         end else begin : g_clr_pri
            assign flag_nx = (flag_r | set_i) & ~clr_i;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) flag_r <= 1'b0;
            else        flag_r <= flag_nx;
         end
         assign q_o    = flag_r;
         assign pend_o = flag_r;
         logic unused_live;
         assign unused_live = live_i;
      end else if (KIND == isr_pkg::CELL_LIVE) begin : g_live
         assign q_o    = live_i;
         assign pend_o = 1'b0;
         logic unused_in;
         assign unused_in = ^{clk, rst_n, set_i, clr_i};
      end else begin : g_zero
         assign q_o    = 1'b0;
         assign pend_o = 1'b0;
         logic unused_in;
         assign unused_in = ^{clk, rst_n, set_i, clr_i, live_i};
      end
   endgenerate
endmodule

// File: rtl/isr_enable_reg.sv
module isr_enable_reg #(
   parameter int unsigned    W    = isr_pkg::ISR_W,
   parameter logic [W-1:0]   MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] en_o
);
   logic [W-1:0] en_r;
   always_ff @(posedge clk) begin
      if (!rst_n)    en_r <= '0;
      else if (wr_i) en_r <= data_i & MASK;
   end
   assign en_o = en_r;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
   parameter int unsigned STAT_W     = isr_pkg::ISR_W,
   parameter int unsigned LIVE_POS   = isr_pkg::POS_DP,
   parameter int unsigned RSV_POS    = isr_pkg::POS_RSV,
   parameter int unsigned SHARED_POS = isr_pkg::POS_SHR,
   parameter bit          SET_WINS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_xfer_a,
   input  logic              evt_xfer_b,
   input  logic              evt_babble,
   input  logic              evt_frame,
   input  logic              evt_cable,
   input  logic              evt_busrst,
   input  logic              evt_resume,
   input  logic              resume_mode,
   input  logic              line_dp,
   input  logic              wr_stat,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_data,
   output logic [STAT_W-1:0] stat_q,
   output logic [STAT_W-1:0] en_q,
   output logic              irq
);
   localparam logic [STAT_W-1:0] ONE_HOT1 = {{(STAT_W-1){1'b0}}, 1'b1};
   localparam logic [STAT_W-1:0] EN_MASK  =
      ~((ONE_HOT1 << LIVE_POS) | (ONE_HOT1 << RSV_POS));

   generate
      if (STAT_W != isr_pkg::ISR_W) begin : g_bad_width
         $error("irq_status_unit: STAT_W must equal the package width");
      end
      if (LIVE_POS >= STAT_W || RSV_POS >= STAT_W || SHARED_POS >= STAT_W) begin : g_bad_pos
         $error("irq_status_unit: bit position out of range");
      end
      if (LIVE_POS == RSV_POS || LIVE_POS == SHARED_POS || RSV_POS == SHARED_POS) begin : g_pos_clash
         $error("irq_status_unit: special bit positions overlap");
      end
   endgenerate

   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] clr_vec;
   logic [STAT_W-1:0] pend_vec;

   isr_event_map #(
      .W     (STAT_W),
      .P_SHR (SHARED_POS)
   ) u_map (
      .evt_xfer_a  (evt_xfer_a),
      .evt_xfer_b  (evt_xfer_b),
      .evt_babble  (evt_babble),
      .evt_frame   (evt_frame),
      .evt_cable   (evt_cable),
      .evt_busrst  (evt_busrst),
      .evt_resume  (evt_resume),
      .resume_mode (resume_mode),
      .set_vec     (set_vec)
   );

   assign clr_vec = {STAT_W{wr_stat}} & wr_data;

   generate
      for (genvar gi = 0; gi < STAT_W; gi++) begin : g_cell
         localparam isr_pkg::cell_kind_e K =
            (gi == LIVE_POS) ? isr_pkg::CELL_LIVE :
            (gi == RSV_POS)  ? isr_pkg::CELL_ZERO : isr_pkg::CELL_LATCH;
         isr_bit_cell #(
            .KIND     (K),
            .SET_WINS (SET_WINS)
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[gi]),
            .clr_i  (clr_vec[gi]),
            .live_i (line_dp),
            .q_o    (stat_q[gi]),
            .pend_o (pend_vec[gi])
         );
      end
   endgenerate

   isr_enable_reg #(
      .W    (STAT_W),
      .MASK (EN_MASK)
   ) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (wr_en),
      .data_i (wr_data),
      .en_o   (en_q)
   );

   assign irq = |(pend_vec & en_q);
endmodule

// File: rtl/isr_checker.sv
module isr_checker #(
   parameter int unsigned W = isr_pkg::ISR_W
) (
   input logic         clk,
   input logic         rst_n,
   input logic         evt_xfer_a,
   input logic         evt_xfer_b,
   input logic         evt_cable,
   input logic         evt_busrst,
   input logic         evt_resume,
   input logic         resume_mode,
   input logic         line_dp,
   input logic         wr_stat,
   input logic [W-1:0] wr_data,
   input logic [W-1:0] stat_q,
   input logic [W-1:0] en_q,
   input logic         irq
);
   p_xfer_a_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_xfer_a |=> stat_q[0]);

   p_cable_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stat && !evt_cable) |=> (stat_q[5] == $past(stat_q[5])));

   p_resume_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_mode && evt_resume) |=> stat_q[6]);

   p_busrst_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!resume_mode && evt_busrst) |=> stat_q[6]);

   p_live_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[7] == line_dp);

   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wr_data[0] && !evt_xfer_a) |=> !stat_q[0]);

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wr_data[1] && evt_xfer_b) |=> stat_q[1]);

   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q[6:0] & en_q[6:0]) == 7'd0) |-> !irq);

   p_rsv_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_q[3] && !en_q[3]);

   p_en_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[7]);
endmodule

bind irq_status_unit isr_checker #(.W(STAT_W)) u_isr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_xfer_a  (evt_xfer_a),
   .evt_xfer_b  (evt_xfer_b),
   .evt_cable   (evt_cable),
   .evt_busrst  (evt_busrst),
   .evt_resume  (evt_resume),
   .resume_mode (resume_mode),
   .line_dp     (line_dp),
   .wr_stat     (wr_stat),
   .wr_data     (wr_data),
   .stat_q      (stat_q),
   .en_q        (en_q),
   .irq         (irq)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_xfer_a = 0, evt_xfer_b = 0, evt_babble = 0, evt_frame = 0;
   logic       evt_cable = 0, evt_busrst = 0, evt_resume = 0;
   logic       resume_mode = 0, line_dp = 0, wr_stat = 0, wr_en = 0;
   logic [7:0] wr_data = '0;
   logic [7:0] stat_q, en_q;
   logic       irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   irq_status_unit dut (
      .clk(clk), .rst_n(rst_n),
      .evt_xfer_a(evt_xfer_a), .evt_xfer_b(evt_xfer_b),
      .evt_babble(evt_babble), .evt_frame(evt_frame),
      .evt_cable(evt_cable), .evt_busrst(evt_busrst),
      .evt_resume(evt_resume), .resume_mode(resume_mode),
      .line_dp(line_dp), .wr_stat(wr_stat), .wr_en(wr_en),
      .wr_data(wr_data), .stat_q(stat_q), .en_q(en_q), .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // all helpers start and end just after a falling edge
   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic write_stat(input logic [7:0] d);
      wr_stat = 1; wr_data = d;
      @(negedge clk);
      wr_stat = 0; wr_data = '0;
   endtask

   task automatic write_en(input logic [7:0] d);
      wr_en = 1; wr_data = d;
      @(negedge clk);
      wr_en = 0; wr_data = '0;
   endtask

   task automatic t_reset();
      check("R1", "status during reset", stat_q & 8'h7F, 8'h00);
      check("R1", "enable during reset", en_q, 8'h00);
      check("R1", "irq during reset", {7'd0, irq}, 8'h00);
      rst_n = 1;
      idle(2);
      check("R1", "status after reset", stat_q, 8'h00);
      check("R1", "irq after reset", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_xfer();
      evt_xfer_a = 1; @(negedge clk); evt_xfer_a = 0;
      check("R2", "channel A done", stat_q, 8'h01);
      evt_xfer_b = 1; @(negedge clk); evt_xfer_b = 0;
      check("R2", "channel B done", stat_q, 8'h03);
      write_stat(8'hFF);
   endtask

   task automatic t_babble_frame();
      evt_babble = 1; evt_frame = 1; @(negedge clk);
      evt_babble = 0; evt_frame = 0;
      check("R3", "babble and frame together", stat_q, 8'h14);
      write_stat(8'hFF);
   endtask

   task automatic t_cable();
      evt_cable = 1; @(negedge clk); evt_cable = 0;
      idle(5);
      check("R4", "cable bit held", stat_q, 8'h20);
      write_stat(8'h20);
      check("R4", "cable bit cleared", stat_q, 8'h00);
   endtask

   task automatic t_shared();
      resume_mode = 0;
      evt_resume = 1; @(negedge clk); evt_resume = 0;
      check("R5", "resume ignored in reset mode", stat_q, 8'h00);
      evt_busrst = 1; @(negedge clk); evt_busrst = 0;
      check("R5", "bus reset in reset mode", stat_q, 8'h40);
      write_stat(8'h40);
      resume_mode = 1;
      evt_busrst = 1; @(negedge clk); evt_busrst = 0;
      check("R5", "bus reset ignored in resume mode", stat_q, 8'h00);
      evt_resume = 1; @(negedge clk); evt_resume = 0;
      check("R5", "resume in resume mode", stat_q, 8'h40);
      write_stat(8'h40);
      resume_mode = 0;
   endtask

   task automatic t_live();
      line_dp = 1; #1;
      check("R6", "live pin high", stat_q, 8'h80);
      @(negedge clk);
      write_stat(8'h80);
      check("R6", "write leaves live bit", stat_q, 8'h80);
      line_dp = 0; #1;
      check("R6", "live pin low", stat_q, 8'h00);
      @(negedge clk);
   endtask

   task automatic t_w1c();
      evt_xfer_a = 1; evt_xfer_b = 1; evt_babble = 1; @(negedge clk);
      evt_xfer_a = 0; evt_xfer_b = 0; evt_babble = 0;
      write_stat(8'h05);
      check("R7", "partial clear", stat_q, 8'h02);
      write_stat(8'h00);
      check("R7", "zero write keeps bits", stat_q, 8'h02);
      write_stat(8'hFF);
      check("R7", "clear all", stat_q, 8'h00);
   endtask

   task automatic t_set_wins();
      evt_xfer_a = 1; @(negedge clk); evt_xfer_a = 0;
      // clear bits 0 and 1 while both see a new event
      wr_stat = 1; wr_data = 8'h03; evt_xfer_a = 1; evt_xfer_b = 1;
      @(negedge clk);
      wr_stat = 0; wr_data = '0; evt_xfer_a = 0; evt_xfer_b = 0;
      check("R8", "set beats clear", stat_q, 8'h03);
      write_stat(8'hFF);
   endtask

   task automatic t_irq();
      evt_xfer_a = 1; @(negedge clk); evt_xfer_a = 0;
      check("R9", "irq with enable off", {7'd0, irq}, 8'h00);
      write_en(8'h01);
      check("R9", "irq with matching enable", {7'd0, irq}, 8'h01);
      write_en(8'h02);
      check("R9", "irq with other enable", {7'd0, irq}, 8'h00);
      write_stat(8'hFF);
      line_dp = 1;
      write_en(8'hFF);
      check("R11", "enable readback masked", en_q, 8'h77);
      check("R9", "live pin never raises irq", {7'd0, irq}, 8'h00);
      line_dp = 0;
      write_en(8'h00);
      check("R11", "enable cleared", en_q, 8'h00);
   endtask

   task automatic t_reserved();
      write_stat(8'h08);
      check("R10", "reserved bit after write", stat_q, 8'h00);
      write_en(8'h08);
      check("R10", "reserved enable bit", en_q, 8'h00);
   endtask

   initial begin
      idle(3);
      t_reset();
      t_xfer();
      t_babble_frame();
      t_cable();
      t_shared();
      t_live();
      t_w1c();
      t_set_wins();
      t_irq();
      t_reserved();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule